// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a successive-approximation converter. An asynchronous trigger line is brought into the clock domain. While the synchronized trigger is high and no conversion runs, the sample/hold control requests sampling. A falling trigger edge switches the sample/hold to hold and starts a binary search. The search tests one bit at a time, from the most significant bit down. The trial code goes to an external DAC, and a one-bit comparator decision comes back from outside.

The trial code is active-low: the bit under test is driven low, untested bits are driven high, and decided bits keep their outcome. Each bit takes two clocks. The first clock lets the DAC settle and the second samples the comparator. A busy flag covers the whole search, and any trigger activity during that time is ignored. When the last bit is decided, the code is coded for the selected output format and latched. It stays there until the next conversion completes. The code is read through a high lane and a low lane, each with an active-low enable.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy_o is 0, dac_n_o is all ones, and the latched result is zero. Both lanes therefore read zero when enabled.
- R2: A conversion starts on the first clock edge that sees a falling trigger edge after two synchronizing flip-flops and one edge-detect register. On that edge busy_o rises and dac_n_o becomes MSB low with all other bits high.
- R3: sh_o follows the synchronized trigger level while idle (1 = sample) and is 0 (hold) for as long as busy_o is high.
- R4: The DAC value is the bitwise inverse of dac_n_o. cmp_i = 1 means the analog input is at or above that value. Each bit is held low for one settling clock, then cmp_i is sampled. If cmp_i is 1 the bit stays low; if 0 it returns high. On the same edge the next lower bit goes low. Bits not yet tested stay high.
- R5: busy_o stays high for exactly 2*WIDTH clock cycles and falls on the edge that decides bit 0.
- R6: Trigger edges that arrive while busy_o is high are ignored: the search in progress is not restarted, and no conversion follows once it ends.
- R7: On the edge where busy_o falls, the result register loads the inverse of the final dac_n_o value. For an ideal comparator this equals the analog input. The register holds that value until the next conversion completes.
- R8: mode_i is sampled on the completion edge. 00 selects straight binary and 01 selects offset binary; both use the search code unchanged. 10 selects two's complement, which is the search code with its MSB inverted. 11 behaves as 01.
- R9: res_hi_o carries result bits WIDTH-1 down to 8 while hi_en_ni is 0, and is high-impedance while hi_en_ni is 1. res_lo_o carries bits 7 down to 0 under lo_en_ni in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous conversion trigger; its falling edge starts a search |
| mode_i | input | 2 | Output coding select |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the DAC value |
| hi_en_ni | input | 1 | Active-low enable of the high lane |
| lo_en_ni | input | 1 | Active-low enable of the low lane |
| sh_o | output | 1 | Sample/hold control, 1 = sample, 0 = hold |
| busy_o | output | 1 | Conversion in progress |
| dac_n_o | output | WIDTH | Active-low trial code to the DAC |
| res_hi_o | output | WIDTH-8 | Result bits WIDTH-1..8, tri-state |
| res_lo_o | output | 8 | Result bits 7..0, tri-state |

## Verification
The assertions assume that the comparator decision depends only on the DAC code the block has presented for at least one clock. They also assume the analog level stays fixed for the whole search, which is what the sample/hold provides. The stimulus meets this by computing cmp_i continuously as an ideal threshold compare of a held integer against the inverted trial code. The stimulus changes that integer only while the block is idle. Trigger pulses are held for several clocks so that both edges pass the synchronizer. Retrigger pulses are injected in the middle of a search to exercise the ignore rule.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Output coding selected by mode_i
    typedef enum logic [1:0] {
        CODE_UNI  = 2'b00,
        CODE_OFS  = 2'b01,
        CODE_TWOS = 2'b10,
        CODE_RSV  = 2'b11
    } code_mode_e;

    // Two clocks per bit: settle the DAC, then take the decision
    typedef enum logic {
        PH_SETTLE = 1'b0,
        PH_DECIDE = 1'b1
    } phase_e;

    // Trigger synchronizer state
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } trig_state_t;

endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync
    import sar_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic level_o,
    output logic fall_o
);

    trig_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], trig_i};
        st_d.prev = st_q.sync[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.sync[1];
    assign fall_o  = st_q.prev & ~st_q.sync[1];

    // R2
    fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int WIDTH = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] trial_n_o,
    output logic             done_o,
    output logic [WIDTH-1:0] code_o
);

    localparam int IDX_W = $clog2(WIDTH);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);
    localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b0, {(WIDTH-1){1'b1}}};

    typedef struct packed {
        logic             busy;
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] trial_n;
    } core_t;

    core_t            cs_d, cs_q;
    logic             done_d;
    logic [IDX_W-1:0] idx_dn;

    always_comb begin
        cs_d   = cs_q;
        done_d = 1'b0;
        idx_dn = cs_q.idx - IDX_W'(1);
        if (!cs_q.busy) begin
            if (start_i) begin
                cs_d.busy    = 1'b1;
                cs_d.phase   = PH_SETTLE;
                cs_d.idx     = TOP_IDX;
                cs_d.trial_n = FIRST_TRIAL;
            end
        end else if (cs_q.phase == PH_SETTLE) begin
            cs_d.phase = PH_DECIDE;
        end else begin
            if (!cmp_i) begin
                cs_d.trial_n[cs_q.idx] = 1'b1;
            end
            if (cs_q.idx == '0) begin
                cs_d.busy = 1'b0;
                done_d    = 1'b1;
            end else begin
                cs_d.idx             = idx_dn;
                cs_d.trial_n[idx_dn] = 1'b0;
                cs_d.phase           = PH_SETTLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q.busy    <= 1'b0;
            cs_q.phase   <= PH_SETTLE;
            cs_q.idx     <= '0;
            cs_q.trial_n <= '1;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign busy_o    = cs_q.busy;
    assign trial_n_o = cs_q.trial_n;
    assign done_o    = done_d;
    assign code_o    = ~cs_d.trial_n;

    // R2
    start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && trial_n_o == FIRST_TRIAL));

    // R4
    untested_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && cs_q.idx != '0) |-> trial_n_o[0]);

    // R4
    settle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && cs_q.phase == PH_SETTLE) |=> $stable(trial_n_o));

    // R6
    no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && cs_q.idx != TOP_IDX) |=> (!busy_o || $stable(trial_n_o[WIDTH-1])));

endmodule

// File: rtl/sar_out.sv
module sar_out
    import sar_pkg::*;
#(
    parameter int WIDTH = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic [WIDTH-1:0] code_i,
    input  logic [1:0]       mode_i,
    input  logic             hi_en_ni,
    input  logic             lo_en_ni,
    output logic [WIDTH-9:0] res_hi_o,
    output logic [7:0]       res_lo_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
    } out_t;

    out_t             os_d, os_q;
    logic [WIDTH-1:0] coded;
    code_mode_e       mode_sel;
    logic [WIDTH-1:0] res_q;

    always_comb begin
        mode_sel = code_mode_e'(mode_i);
        coded    = code_i;
        if (mode_sel == CODE_TWOS) begin
            coded[MSB] = ~code_i[MSB];
        end
        os_d = os_q;
        if (done_i) begin
            os_d.res = coded;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign res_q    = os_q.res;
    assign res_hi_o = hi_en_ni ? 'z : res_q[MSB:8];
    assign res_lo_o = lo_en_ni ? 'z : res_q[7:0];

    // R7
    hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |=> $stable(res_q));

    // R8
    twos_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && mode_i == 2'b10) |=> (res_q[MSB] != $past(code_i[MSB])));

    // R8
    plain_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && mode_i != 2'b10) |=> (res_q == $past(code_i)));

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int WIDTH = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic [1:0]       mode_i,
    input  logic             cmp_i,
    input  logic             hi_en_ni,
    input  logic             lo_en_ni,
    output logic             sh_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] dac_n_o,
    output logic [WIDTH-9:0] res_hi_o,
    output logic [7:0]       res_lo_o
);

    localparam int LEN_W = $clog2(2 * WIDTH + 1) + 1;

    logic             trig_lvl;
    logic             trig_fall;
    logic             done;
    logic [WIDTH-1:0] code;

    sar_trig_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .level_o(trig_lvl),
        .fall_o (trig_fall)
    );

    sar_core #(.WIDTH(WIDTH)) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (trig_fall),
        .cmp_i    (cmp_i),
        .busy_o   (busy_o),
        .trial_n_o(dac_n_o),
        .done_o   (done),
        .code_o   (code)
    );

    sar_out #(.WIDTH(WIDTH)) u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .done_i  (done),
        .code_i  (code),
        .mode_i  (mode_i),
        .hi_en_ni(hi_en_ni),
        .lo_en_ni(lo_en_ni),
        .res_hi_o(res_hi_o),
        .res_lo_o(res_lo_o)
    );

    assign sh_o = trig_lvl & ~busy_o;

    // Conversion length tracker, used only by the length check below
    logic [LEN_W-1:0] blen_d, blen_q;

    always_comb begin
        blen_d = busy_o ? blen_q + LEN_W'(1) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            blen_q <= '0;
        end else begin
            blen_q <= blen_d;
        end
    end

    // R5
    busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (blen_q == LEN_W'(2 * WIDTH)));

    // R3
    hold_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (sh_o == 1'b0 && $past(trig_lvl) == 1'b0));

endmodule

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;

    localparam int W = 14;
    localparam int WD_LIMIT = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         hi_en_n = 1'b0;
    logic         lo_en_n = 1'b0;
    logic [W:0]   ana = '0;
    logic         cmp;
    logic         sh;
    logic         busy;
    logic [W-1:0] dac_n;
    wire  [W-9:0] hi_w;
    wire  [7:0]   lo_w;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // Ideal threshold comparator: input at or above the DAC value
    assign cmp = (ana >= {1'b0, ~dac_n});

    for (genvar g = 0; g < W - 8; g++) begin : g_pu_hi
        pullup (hi_w[g]);
    end
    for (genvar g = 0; g < 8; g++) begin : g_pu_lo
        pullup (lo_w[g]);
    end

    sar_seq #(.WIDTH(W)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .trig_i  (trig),
        .mode_i  (mode),
        .cmp_i   (cmp),
        .hi_en_ni(hi_en_n),
        .lo_en_ni(lo_en_n),
        .sh_o    (sh),
        .busy_o  (busy),
        .dac_n_o (dac_n),
        .res_hi_o(hi_w),
        .res_lo_o(lo_w)
    );

    // Behavioural reference
    bit           m_s0, m_s1, m_prv, m_busy;
    int           m_cnt, m_idx;
    logic [W-1:0] m_acc, m_res;

    function automatic logic [W-1:0] apply_code(logic [W-1:0] c, logic [1:0] md);
        logic [W-1:0] r = c;
        if (md == 2'b10) r[W-1] = ~r[W-1];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_prv = 0; m_busy = 0;
            m_cnt = 0; m_idx = 0; m_acc = '0; m_res = '0;
        end else begin
            bit fall;
            fall  = m_prv & ~m_s1;
            m_prv = m_s1;
            m_s1  = m_s0;
            m_s0  = trig;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt % 2 == 0) begin
                    logic [W-1:0] bitv;
                    bitv = W'(1) << m_idx;
                    if (int'(ana) >= int'(m_acc | bitv)) m_acc = m_acc | bitv;
                    if (m_idx == 0) begin
                        m_busy = 0;
                        m_res  = apply_code(m_acc, mode);
                    end else begin
                        m_idx--;
                    end
                end
            end else if (fall) begin
                m_busy = 1; m_cnt = 0; m_idx = W - 1; m_acc = '0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [W-1:0] e_dac;
            logic [W-9:0] e_hi;
            logic [7:0]   e_lo;
            e_dac = m_busy ? ~(m_acc | (W'(1) << m_idx)) : ~m_acc;
            e_hi  = hi_en_n ? '1 : m_res[W-1:8];
            e_lo  = lo_en_n ? '1 : m_res[7:0];
            chk(busy == m_busy, "R5 busy", 32'(busy), 32'(m_busy));
            chk(sh == (m_s1 & ~m_busy), "R3 sh", 32'(sh), 32'(m_s1 & ~m_busy));
            chk(dac_n == e_dac, "R4 dac", 32'(dac_n), 32'(e_dac));
            chk(hi_w == e_hi, "R9 hi lane", 32'(hi_w), 32'(e_hi));
            chk(lo_w == e_lo, "R9 lo lane", 32'(lo_w), 32'(e_lo));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // One conversion with optional retrigger in the middle
    task automatic convert(input int a, input logic [1:0] md, input bit retrig);
        @(negedge clk);
        ana  = (W+1)'(a);
        mode = md;
        hi_en_n = 1'b0;
        lo_en_n = 1'b0;
        trig = 1'b1;
        repeat (4) @(negedge clk);
        trig = 1'b0;
        repeat (4) @(negedge clk);
        // R2: search under way, hold selected
        chk(busy == 1'b1 && sh == 1'b0, "R2 start", 32'({busy, sh}), 32'h2);
        if (retrig) begin
            repeat (3) @(negedge clk);
            trig = 1'b1;
            repeat (4) @(negedge clk);
            trig = 1'b0;
        end
        repeat (2 * W + 4) @(negedge clk);
        // R7/R8: latched code against ideal quantizer
        chk(busy == 1'b0, "R6 idle after search", 32'(busy), 0);
        chk({hi_w, lo_w} == apply_code(W'(a), md), "R7 R8 result",
            32'({hi_w, lo_w}), 32'(apply_code(W'(a), md)));
    endtask

    initial begin
        int seed = 32'h1F3A;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(dac_n == '1, "R1 dac", 32'(dac_n), 32'((1 << W) - 1));
        chk({hi_w, lo_w} == '0, "R1 result", 32'({hi_w, lo_w}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        convert(0, 2'b00, 0);
        convert((1 << W) - 1, 2'b00, 0);
        convert(1, 2'b01, 0);
        convert(1 << (W - 1), 2'b10, 0);
        convert((1 << (W - 1)) - 1, 2'b10, 0);
        convert(12345 % (1 << W), 2'b11, 0);
        // R6: retrigger during a search
        convert(5461, 2'b00, 1);
        convert(10922, 2'b10, 1);
        for (int i = 0; i < 8; i++) begin
            seed = seed * 1103515245 + 12345;
            convert((seed >>> 8) & ((1 << W) - 1), 2'(i % 4), 0);
        end

        // R9: lane enables on a held result, value 0x2A5C
        convert(16'h2A5C % (1 << W), 2'b00, 0);
        hi_en_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(hi_w == '1 && lo_w == 8'h5C, "R9 hi off", 32'({hi_w, lo_w}), 32'({{(W-8){1'b1}}, 8'h5C}));
        lo_en_n = 1'b1;
        hi_en_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(lo_w == 8'hFF, "R9 lo off", 32'(lo_w), 32'hFF);
        // R7: result held while idle with trigger toggling high
        trig = 1'b1;
        repeat (5) @(negedge clk);
        chk(sh == 1'b1, "R3 sample while idle", 32'(sh), 1);
        lo_en_n = 1'b0;
        @(negedge clk);
        chk({hi_w, lo_w} == W'(16'h2A5C), "R7 held", 32'({hi_w, lo_w}), 32'h2A5C);
        trig = 1'b0;
        repeat (2 * W + 8) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule